// File: doc/BRIEF.md
# Two-Line Atomic Ownership Sequencer

This block runs one indivisible read-modify-write whose operand covers one cache line or two neighbouring lines, and it does so without locking the whole memory system. It accepts a request with two line addresses and a flag that says whether the operand really spans two lines. It first asks the load side to empty its outstanding loads. It then asks a coherence agent for exclusive ownership of the lines one at a time, always the smaller address first. As each line becomes exclusive, the block starts holding back snoops aimed at that line. Once every needed line is exclusive and shielded, it starts the datapath operation. After the operation it asks the store side to drain, and then it lifts the snoop shield from all held lines in the same cycle.

The addresses may arrive in either order, and the block sorts them itself. A snoop that targets a shielded line is stalled, never dropped: its ready output stays low until the line is released. Only one sequence runs at a time. A one-cycle completion pulse marks the release.

Top module: `dual_line_atomic_seq`

## Requirements
- R1: `req_ready` is high only while no sequence is running. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the cycle after the release, and a request presented while busy is ignored.
- R2: In the cycle after acceptance, `ld_drain_req` goes high and stays high until `ld_drain_done` is seen. No `own_req` is raised before that.
- R3: When the operand spans two distinct lines (`req_two_line`=1 and the addresses differ), the first `own_addr` issued is the smaller of the two addresses and the second is the larger, whatever order they arrived in.
- R4: `own_req` stays high with a stable `own_addr` until a cycle with `own_grant` high. There is no timeout.
- R5: A line becomes shielded on the edge where its grant is seen. The request for the second line starts only in the cycle after the first line's grant, when the first line is already shielded.
- R6: `op_start` is high only while all needed lines are shielded. It stays high until `op_done`.
- R7: After `op_done`, `st_drain_req` stays high until `st_drain_done`, and the lines stay shielded throughout.
- R8: On the edge where `st_drain_done` is seen, the shield is removed from all held lines together. `done` is high for exactly that following cycle.
- R9: A snoop (`snp_valid`=1) whose `snp_addr` equals a shielded line sees `snp_ready`=0. Any other snoop, and any cycle without a snoop, sees `snp_ready`=1.
- R10: With `req_two_line`=0, or with equal addresses, only one acquire is made, using `req_addr_a`, and `req_addr_b` is never shielded.
- R11: Reset (active low `rst_n`) puts the block idle: `req_ready`=1, every request and `done` output low, and no line shielded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Atomic operation request |
| req_ready | output | 1 | Sequencer idle and ready to accept |
| req_addr_a | input | LINE_AW | First operand line address |
| req_addr_b | input | LINE_AW | Second operand line address |
| req_two_line | input | 1 | Operand spans two lines |
| ld_drain_req | output | 1 | Ask load buffer to empty |
| ld_drain_done | input | 1 | Load buffer empty |
| own_req | output | 1 | Ask coherence agent for exclusive ownership |
| own_addr | output | LINE_AW | Line being acquired |
| own_grant | input | 1 | Line is now exclusive |
| op_start | output | 1 | Start the read-modify-write |
| op_done | input | 1 | Operation finished |
| st_drain_req | output | 1 | Ask store buffer to drain |
| st_drain_done | input | 1 | Store buffer drained |
| snp_valid | input | 1 | Incoming snoop present |
| snp_addr | input | LINE_AW | Snoop line address |
| snp_ready | output | 1 | Snoop may proceed |
| done | output | 1 | One-cycle pulse at release |

## Verification
On every cycle the assertions check the handshake invariants. Ownership requests hold steady until granted. The operation and the store drain only run while the needed lines are shielded. The second acquire always targets a larger address than the first shielded line. Both shields fall in the same cycle as the `done` pulse, and a snoop to a shielded line never reads as ready. Other properties depend on the stimulus and only the bench scenarios can show them: the sorting of reversed and extreme address pairs, the single-line path when the addresses are equal or the flag is clear, a request ignored while busy, and recovery when reset arrives in the middle of a sequence.

// File: rtl/dla_pkg.sv
package dla_pkg;

  localparam int DLA_MAX_AW = 64;
  localparam int DLA_NLINES = 2;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_LDRAIN = 3'd1,
    S_ACQ_LO = 3'd2,
    S_ACQ_HI = 3'd3,
    S_OP     = 3'd4,
    S_SDRAIN = 3'd5,
    S_REL    = 3'd6
  } seq_state_t;

  // True when the pair must be swapped so the smaller line comes first.
  function automatic logic need_swap(input logic [DLA_MAX_AW-1:0] a,
                                     input logic [DLA_MAX_AW-1:0] b);
    return b < a;
  endfunction

  // True when two separate lines really have to be acquired.
  function automatic logic spans_two(input logic two_flag,
                                     input logic [DLA_MAX_AW-1:0] a,
                                     input logic [DLA_MAX_AW-1:0] b);
    return two_flag && (a != b);
  endfunction

endpackage

// File: rtl/dla_order.sv
module dla_order #(
  parameter int AW = 26
) (
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  input  logic          two_line,
  output logic [AW-1:0] line_lo,
  output logic [AW-1:0] line_hi,
  output logic          dual
);
  import dla_pkg::*;

  localparam int PADW = DLA_MAX_AW - AW;

  logic [DLA_MAX_AW-1:0] wide_a;
  logic [DLA_MAX_AW-1:0] wide_b;
  logic                  swap;

  assign wide_a = {{PADW{1'b0}}, addr_a};
  assign wide_b = {{PADW{1'b0}}, addr_b};
  assign dual   = spans_two(two_line, wide_a, wide_b);
  assign swap   = dual && need_swap(wide_a, wide_b);

  always_comb begin
    if (!dual) begin
      line_lo = addr_a;
      line_hi = addr_a;
    end else if (swap) begin
      line_lo = addr_b;
      line_hi = addr_a;
    end else begin
      line_lo = addr_a;
      line_hi = addr_b;
    end
  end

endmodule

// File: rtl/dla_seq_fsm.sv
module dla_seq_fsm #(
  parameter int AW     = 26,
  parameter int NLINES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [AW-1:0]              lo_in,
  input  logic [AW-1:0]              hi_in,
  input  logic                       dual_in,
  output logic                       req_ready,
  output logic                       ld_drain_req,
  input  logic                       ld_drain_done,
  output logic                       own_req,
  output logic [AW-1:0]              own_addr,
  input  logic                       own_grant,
  output logic                       op_start,
  input  logic                       op_done,
  output logic                       st_drain_req,
  input  logic                       st_drain_done,
  output logic                       done,
  output logic [NLINES-1:0]          blk,
  output logic [NLINES-1:0][AW-1:0]  lines_q,
  output logic                       dual_q,
  output logic                       accept_evt,
  output logic                       grant_evt,
  output logic                       release_evt
);
  import dla_pkg::*;

  seq_state_t st;

  assign accept_evt  = (st == S_IDLE) && req_valid;
  assign grant_evt   = own_req && own_grant;
  assign release_evt = (st == S_SDRAIN) && st_drain_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      blk     <= '0;
      lines_q <= '0;
      dual_q  <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (accept_evt) begin
            lines_q[0] <= lo_in;
            lines_q[1] <= hi_in;
            dual_q     <= dual_in;
            st         <= S_LDRAIN;
          end
        end
        S_LDRAIN: begin
          if (ld_drain_done) st <= S_ACQ_LO;
        end
        S_ACQ_LO: begin
          if (own_grant) begin
            blk[0] <= 1'b1;
            st     <= dual_q ? S_ACQ_HI : S_OP;
          end
        end
        S_ACQ_HI: begin
          if (own_grant) begin
            blk[1] <= 1'b1;
            st     <= S_OP;
          end
        end
        S_OP: begin
          if (op_done) st <= S_SDRAIN;
        end
        S_SDRAIN: begin
          if (release_evt) begin
            blk <= '0;
            st  <= S_REL;
          end
        end
        S_REL: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready    = (st == S_IDLE);
    ld_drain_req = (st == S_LDRAIN);
    own_req      = (st == S_ACQ_LO) || (st == S_ACQ_HI);
    own_addr     = (st == S_ACQ_HI) ? lines_q[1] : lines_q[0];
    op_start     = (st == S_OP);
    st_drain_req = (st == S_SDRAIN);
    done         = (st == S_REL);
  end

endmodule

// File: rtl/dla_snoop_gate.sv
module dla_snoop_gate #(
  parameter int AW     = 26,
  parameter int NLINES = 2
) (
  input  logic                      snp_valid,
  input  logic [AW-1:0]             snp_addr,
  input  logic [NLINES-1:0]         blk,
  input  logic [NLINES-1:0][AW-1:0] lines_q,
  output logic                      snp_ready,
  output logic                      snp_stall
);
  logic [NLINES-1:0] hit;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    assign hit[i] = blk[i] && (snp_addr == lines_q[i]);
  end

  assign snp_stall = snp_valid && (|hit);
  assign snp_ready = !snp_stall;

endmodule

// File: rtl/dual_line_atomic_seq.sv
module dual_line_atomic_seq #(
  parameter int LINE_AW = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LINE_AW-1:0] req_addr_a,
  input  logic [LINE_AW-1:0] req_addr_b,
  input  logic               req_two_line,
  output logic               ld_drain_req,
  input  logic               ld_drain_done,
  output logic               own_req,
  output logic [LINE_AW-1:0] own_addr,
  input  logic               own_grant,
  output logic               op_start,
  input  logic               op_done,
  output logic               st_drain_req,
  input  logic               st_drain_done,
  input  logic               snp_valid,
  input  logic [LINE_AW-1:0] snp_addr,
  output logic               snp_ready,
  output logic               done
);
  localparam int NLINES = dla_pkg::DLA_NLINES;

  logic [LINE_AW-1:0]              ord_lo;
  logic [LINE_AW-1:0]              ord_hi;
  logic                            ord_dual;
  logic [NLINES-1:0]               blk;
  logic [NLINES-1:0][LINE_AW-1:0]  lines_q;
  logic                            dual_q;
  logic                            accept_evt;
  logic                            grant_evt;
  logic                            release_evt;
  logic                            snp_stall;

  dla_order #(.AW(LINE_AW)) u_order (
    .addr_a   (req_addr_a),
    .addr_b   (req_addr_b),
    .two_line (req_two_line),
    .line_lo  (ord_lo),
    .line_hi  (ord_hi),
    .dual     (ord_dual)
  );

  dla_seq_fsm #(.AW(LINE_AW), .NLINES(NLINES)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .lo_in         (ord_lo),
    .hi_in         (ord_hi),
    .dual_in       (ord_dual),
    .req_ready     (req_ready),
    .ld_drain_req  (ld_drain_req),
    .ld_drain_done (ld_drain_done),
    .own_req       (own_req),
    .own_addr      (own_addr),
    .own_grant     (own_grant),
    .op_start      (op_start),
    .op_done       (op_done),
    .st_drain_req  (st_drain_req),
    .st_drain_done (st_drain_done),
    .done          (done),
    .blk           (blk),
    .lines_q       (lines_q),
    .dual_q        (dual_q),
    .accept_evt    (accept_evt),
    .grant_evt     (grant_evt),
    .release_evt   (release_evt)
  );

  dla_snoop_gate #(.AW(LINE_AW), .NLINES(NLINES)) u_snoop (
    .snp_valid (snp_valid),
    .snp_addr  (snp_addr),
    .blk       (blk),
    .lines_q   (lines_q),
    .snp_ready (snp_ready),
    .snp_stall (snp_stall)
  );

endmodule

// File: rtl/dla_seq_chk.sv
module dla_seq_chk #(
  parameter int AW = 26
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          ld_drain_req,
  input logic          own_req,
  input logic [AW-1:0] own_addr,
  input logic          own_grant,
  input logic          op_start,
  input logic          op_done,
  input logic          st_drain_req,
  input logic          st_drain_done,
  input logic          done,
  input logic          snp_valid,
  input logic [AW-1:0] snp_addr,
  input logic          snp_ready,
  input logic [1:0]    blk,
  input logic [AW-1:0] lo_q,
  input logic [AW-1:0] hi_q,
  input logic          dual_q
);

  a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ld_drain_req && !own_req && !op_start && !st_drain_req && blk == 2'b00);

  a_r2_drain_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(own_req) && !blk[0]) |-> $past(ld_drain_req));

  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (own_req && blk[0]) |-> (own_addr > lo_q));

  a_r4_own_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (own_req && !own_grant) |=> (own_req && $stable(own_addr)));

  a_r5_lo_before_hi: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk[1]) |-> blk[0]);

  a_r6_op_shielded: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> (blk[0] && (blk[1] || !dual_q)));

  a_r6_op_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !op_done) |=> op_start);

  a_r7_drain_shielded: assert property (@(posedge clk) disable iff (!rst_n)
    st_drain_req |-> blk[0]);

  a_r7_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_drain_req && !st_drain_done) |=> st_drain_req);

  a_r8_release_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blk[0]) |-> (done && !blk[1]));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_stall_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && blk[0] && snp_addr == lo_q) |-> !snp_ready);

  a_r9_stall_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && blk[1] && snp_addr == hi_q) |-> !snp_ready);

  a_r10_single_no_hi: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_q |-> !blk[1]);

endmodule

bind dual_line_atomic_seq dla_seq_chk #(.AW(LINE_AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .ld_drain_req  (ld_drain_req),
  .own_req       (own_req),
  .own_addr      (own_addr),
  .own_grant     (own_grant),
  .op_start      (op_start),
  .op_done       (op_done),
  .st_drain_req  (st_drain_req),
  .st_drain_done (st_drain_done),
  .done          (done),
  .snp_valid     (snp_valid),
  .snp_addr      (snp_addr),
  .snp_ready     (snp_ready),
  .blk           (blk),
  .lo_q          (lines_q[0]),
  .hi_q          (lines_q[1]),
  .dual_q        (dual_q)
);

// File: tb/sim_dual_line_atomic_seq.sv
module sim_dual_line_atomic_seq;

  localparam int AW = 16;
  localparam logic [AW-1:0] FAR_ADDR = 16'hABCD;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr_a = '0;
  logic [AW-1:0] req_addr_b = '0;
  logic          req_two_line = 1'b0;
  logic          ld_drain_req;
  logic          ld_drain_done = 1'b0;
  logic          own_req;
  logic [AW-1:0] own_addr;
  logic          own_grant = 1'b0;
  logic          op_start;
  logic          op_done = 1'b0;
  logic          st_drain_req;
  logic          st_drain_done = 1'b0;
  logic          snp_valid = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_ready;
  logic          done;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  dual_line_atomic_seq #(.LINE_AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr_a(req_addr_a), .req_addr_b(req_addr_b), .req_two_line(req_two_line),
    .ld_drain_req(ld_drain_req), .ld_drain_done(ld_drain_done),
    .own_req(own_req), .own_addr(own_addr), .own_grant(own_grant),
    .op_start(op_start), .op_done(op_done),
    .st_drain_req(st_drain_req), .st_drain_done(st_drain_done),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_ready(snp_ready),
    .done(done)
  );

  typedef struct packed {
    logic [AW-1:0] a;
    logic [AW-1:0] b;
    logic          two;
    logic [3:0]    lat;
  } vec_t;

  localparam vec_t VT [6] = '{
    '{16'h0010, 16'h0011, 1'b1, 4'd0},
    '{16'h0200, 16'h01FF, 1'b1, 4'd2},
    '{16'h0040, 16'h0041, 1'b0, 4'd1},
    '{16'h0077, 16'h0077, 1'b1, 4'd0},
    '{16'hFFFF, 16'h0000, 1'b1, 4'd3},
    '{16'h1235, 16'h1234, 1'b1, 4'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic probe(input logic [AW-1:0] addr, input logic exp_rdy, input string tag);
    snp_valid = 1'b1;
    snp_addr  = addr;
    #1;
    chk(tag, {31'd0, snp_ready}, {31'd0, exp_rdy});
    snp_valid = 1'b0;
  endtask

  task automatic run_op(input logic [AW-1:0] a, input logic [AW-1:0] b,
                        input logic two, input int lat, input bit inject);
    logic          edual;
    logic [AW-1:0] elo;
    logic [AW-1:0] ehi;
    edual = two && (a != b);
    elo   = edual ? ((a < b) ? a : b) : a;
    ehi   = edual ? ((a < b) ? b : a) : a;

    @(negedge clk);
    chk("R1 idle ready", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_addr_a = a; req_addr_b = b; req_two_line = two;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 busy not ready", {31'd0, req_ready}, 32'd0);
    chk("R2 load drain raised", {31'd0, ld_drain_req}, 32'd1);
    chk("R2 no acquire yet", {31'd0, own_req}, 32'd0);
    for (int i = 0; i < lat; i++) @(negedge clk);
    chk("R2 load drain held", {31'd0, ld_drain_req}, 32'd1);
    chk("R2 still no acquire", {31'd0, own_req}, 32'd0);
    ld_drain_done = 1'b1;
    @(negedge clk);
    ld_drain_done = 1'b0;
    chk("R2 load drain cleared", {31'd0, ld_drain_req}, 32'd0);
    chk("R3 first acquire", {31'd0, own_req}, 32'd1);
    chk("R3 first address low", {16'd0, own_addr}, {16'd0, elo});
    if (inject) begin
      req_valid = 1'b1; req_addr_a = FAR_ADDR; req_addr_b = FAR_ADDR + 16'd1;
      #1;
      chk("R1 request ignored busy", {31'd0, req_ready}, 32'd0);
    end
    for (int i = 0; i < lat; i++) @(negedge clk);
    if (inject) @(negedge clk);
    req_valid = 1'b0;
    chk("R4 acquire held", {31'd0, own_req}, 32'd1);
    chk("R4 address stable", {16'd0, own_addr}, {16'd0, elo});
    own_grant = 1'b1;
    @(negedge clk);
    own_grant = 1'b0;
    probe(elo, 1'b0, "R9 low line stalled");
    if (edual) begin
      chk("R5 second acquire", {31'd0, own_req}, 32'd1);
      chk("R3 second address high", {16'd0, own_addr}, {16'd0, ehi});
      chk("R6 no op before second", {31'd0, op_start}, 32'd0);
      probe(ehi, 1'b1, "R9 high line open before grant");
      for (int i = 0; i < lat; i++) @(negedge clk);
      own_grant = 1'b1;
      @(negedge clk);
      own_grant = 1'b0;
    end
    chk("R6 op started", {31'd0, op_start}, 32'd1);
    chk("R10 acquires finished", {31'd0, own_req}, 32'd0);
    probe(ehi, 1'b0, "R9 high line stalled");
    probe(FAR_ADDR, 1'b1, "R9 unrelated snoop passes");
    if (!edual && a != b) probe(b, 1'b1, "R10 second address not shielded");
    for (int i = 0; i < lat; i++) @(negedge clk);
    chk("R6 op held", {31'd0, op_start}, 32'd1);
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
    chk("R7 store drain raised", {31'd0, st_drain_req}, 32'd1);
    probe(elo, 1'b0, "R7 shield held in drain");
    for (int i = 0; i < lat; i++) @(negedge clk);
    chk("R7 store drain held", {31'd0, st_drain_req}, 32'd1);
    st_drain_done = 1'b1;
    @(negedge clk);
    st_drain_done = 1'b0;
    chk("R8 done pulse", {31'd0, done}, 32'd1);
    probe(elo, 1'b1, "R8 low released");
    probe(ehi, 1'b1, "R8 high released");
    chk("R1 not ready on release", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    chk("R8 done one cycle", {31'd0, done}, 32'd0);
    chk("R1 ready again", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R11 reset outputs", {27'd0, ld_drain_req, own_req, op_start, st_drain_req, done}, 32'd0);
    rst_n = 1'b1;

    foreach (VT[k]) run_op(VT[k].a, VT[k].b, VT[k].two, int'(VT[k].lat), 1'b0);

    // Busy-time request must not disturb the running sequence.
    run_op(16'h0300, 16'h02FF, 1'b1, 1, 1'b1);

    // Reset in the middle of a two-line sequence.
    @(negedge clk);
    req_valid = 1'b1; req_addr_a = 16'h0500; req_addr_b = 16'h0501; req_two_line = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ld_drain_done = 1'b1;
    @(negedge clk);
    ld_drain_done = 1'b0;
    own_grant = 1'b1;
    @(negedge clk);
    own_grant = 1'b0;
    probe(16'h0500, 1'b0, "R5 low shielded before reset");
    rst_n = 1'b0;
    @(negedge clk);
    probe(16'h0500, 1'b1, "R11 shield cleared by reset");
    chk("R11 ready in reset", {31'd0, req_ready}, 32'd1);
    chk("R11 acquire dropped", {31'd0, own_req}, 32'd0);
    rst_n = 1'b1;
    run_op(16'h0800, 16'h0801, 1'b1, 0, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule